// File: doc/BRIEF.md
# Paged Edge-Interrupt GPIO Register Block

This block is a byte-wide register file for a 48-line digital I/O device, organised as six 8-bit ports. A host writes a port's output byte and reads back the synchronised pin levels of that port. The lower three ports (lines 0 to 23) also carry edge-capture interrupt logic. Each of those lines has a polarity bit, an enable bit and an identification bit. The interrupt output is asserted while any identification bit is set.

The three per-line banks share one three-byte window, one byte per interrupt-capable port. A page field in the page/lock register selects which bank the window shows. The same register holds one write-lock bit per port. A captured edge is cleared by writing its enable bit to 0 and then back to 1; there is no write-one-to-clear. The register interface is plain: a write takes effect at the clock edge on which the write strobe is high, and read data is a combinational function of the address. No valid/ready handshake is used, because every access completes in one cycle and never stalls.

Top module: `pgio_irq_regs`

## Requirements
- R1: After reset, every bit of `pin_out` is 0, and the page/lock register reads 0x00. The pending register reads 0x00, the window reads 0x00 on every page, and `irq` is low.
- R2: Offsets 0 to 5 are the data registers of ports 0 to 5. A write drives that port's byte of `pin_out` from the next clock edge. A read returns the port's pins as sampled by a two-flop synchroniser.
- R3: The page/lock register is at offset 7. Bits 7:6 are the page and bits 5:0 are lock bits, where bit n locks port n. A write to a locked port's data register leaves `pin_out` unchanged.
- R4: An enabled line with polarity 1 captures a rising edge, and one with polarity 0 captures a falling edge. The opposite edge is not captured, and a disabled line never captures.
- R5: The window is at offsets 8, 9 and 10, for ports 0, 1 and 2. Page 01 reads and writes the polarity bytes, and page 10 reads and writes the enable bytes.
- R6: Page 11 makes the window return the captured-edge identification bits. Writing an enable bit to 0 clears that line's identification bit. Writing it back to 1 does not create a capture.
- R7: In the pending register at offset 6, bit p (p = 0, 1, 2) is 1 exactly when port p has a nonzero identification byte. Bits 7:3 read 0.
- R8: `irq` is high exactly when the pending register is nonzero.
- R9: On page 00 the window reads 0 and writes to it are ignored. On page 11 writes to the window are ignored.
- R10: Edges on lines 24 to 47 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pin_in | input | 48 | Pin levels, asynchronous |
| pin_out | output | 48 | Port output bytes |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. Polarity and enable are written only while the pins of the affected lines are steady. A line is never re-enabled in the same cycle as one of its synchronised edges. `pin_in` is otherwise free to change at any time. The stimulus changes pins only on falling clock edges. It waits at least four cycles after each pin change before touching the window or the enables, so the synchroniser and the edge detector have settled before any enable write.

// File: rtl/pgio_pkg.sv
package pgio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'b00,
    PG_POL  = 2'b01,
    PG_EN   = 2'b10,
    PG_ID   = 2'b11
  } page_e;
endpackage

// File: rtl/pgio_sync.sv
module pgio_sync #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pgio_data_port.sv
module pgio_data_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         lock,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (we && !lock) q <= wd;
  end

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> $stable(q));
endmodule

// File: rtl/pgio_irq_port.sv
module pgio_irq_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic         pol_we,
  input  logic         en_we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] pol,
  output logic [W-1:0] en,
  output logic [W-1:0] id
);
  logic [W-1:0] prev;
  logic [W-1:0] hit;
  logic [W-1:0] en_n;

  // a qualifying transition of the synchronised level, per line polarity
  assign hit  = (pin_s & ~prev & pol) | (~pin_s & prev & ~pol);
  assign en_n = en_we ? wd : en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      pol  <= '0;
      en   <= '0;
      id   <= '0;
    end else begin
      prev <= pin_s;
      if (pol_we) pol <= wd;
      en <= en_n;
      id <= (id | (hit & en_n)) & en_n;
    end
  end

  assert_clear_on_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> ((id & ~$past(wd)) == '0));

  assert_id_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(id & ~$past(id))) |-> (|$past(hit)));
endmodule

// File: rtl/pgio_irq_regs.sv
module pgio_irq_regs #(
  parameter int NUM_PORTS     = 6,
  parameter int PORT_W        = 8,
  parameter int NUM_IRQ_PORTS = 3,
  parameter int ADDR_W        = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wen,
  input  logic [PORT_W-1:0]           reg_wdata,
  output logic [PORT_W-1:0]           reg_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic                        irq
);
  import pgio_pkg::*;

  localparam int LINES   = NUM_PORTS * PORT_W;
  localparam int ILINES  = NUM_IRQ_PORTS * PORT_W;
  localparam int PEND_OFS = NUM_PORTS;
  localparam int PAGE_OFS = NUM_PORTS + 1;
  localparam int WIN_OFS  = NUM_PORTS + 2;
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] PAGE_A = ADDR_W'(PAGE_OFS);

  logic [LINES-1:0]         pin_s;
  page_e                    page_q;
  logic [NUM_PORTS-1:0]     lock_q;
  logic [ILINES-1:0]        pol_bus, en_bus, id_bus;
  logic [NUM_IRQ_PORTS-1:0] pend;
  logic                     page_we;

  pgio_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  assign page_we = reg_wen && (reg_addr == PAGE_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else if (page_we) begin
      page_q <= page_e'(reg_wdata[PORT_W-1 -: 2]);
      lock_q <= reg_wdata[NUM_PORTS-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_data
    logic dwe;
    assign dwe = reg_wen && (reg_addr == ADDR_W'(p));
    pgio_data_port #(.W(PORT_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .we(dwe), .lock(lock_q[p]),
      .wd(reg_wdata), .q(pin_out[p*PORT_W +: PORT_W])
    );
  end

  for (genvar k = 0; k < NUM_IRQ_PORTS; k++) begin : g_irq
    logic win_we;
    assign win_we = reg_wen && (reg_addr == ADDR_W'(WIN_OFS + k));
    pgio_irq_port #(.W(PORT_W)) u_ip (
      .clk(clk), .rst_n(rst_n),
      .pin_s(pin_s[k*PORT_W +: PORT_W]),
      .pol_we(win_we && (page_q == PG_POL)),
      .en_we(win_we && (page_q == PG_EN)),
      .wd(reg_wdata),
      .pol(pol_bus[k*PORT_W +: PORT_W]),
      .en(en_bus[k*PORT_W +: PORT_W]),
      .id(id_bus[k*PORT_W +: PORT_W])
    );
    assign pend[k] = |id_bus[k*PORT_W +: PORT_W];
  end

  assign irq = |pend;

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (reg_addr == ADDR_W'(p)) reg_rdata = pin_s[p*PORT_W +: PORT_W];
    if (reg_addr == PEND_A) reg_rdata = PORT_W'(pend);
    if (reg_addr == PAGE_A) reg_rdata = PORT_W'({page_q, lock_q});
    for (int k = 0; k < NUM_IRQ_PORTS; k++)
      if (reg_addr == ADDR_W'(WIN_OFS + k)) begin
        case (page_q)
          PG_POL:  reg_rdata = pol_bus[k*PORT_W +: PORT_W];
          PG_EN:   reg_rdata = en_bus[k*PORT_W +: PORT_W];
          PG_ID:   reg_rdata = id_bus[k*PORT_W +: PORT_W];
          default: reg_rdata = '0;
        endcase
      end
  end

  assert_page0_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && page_q == PG_NONE && reg_addr >= ADDR_W'(WIN_OFS))
      |=> ($stable(pol_bus) && $stable(en_bus)));

  assert_irq_needs_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|id_bus));

  assert_no_pend_on_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (|$past(en_bus)));
endmodule

// File: tb/pgio_irq_regs_test.sv
module pgio_irq_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wen = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pgio_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  // {page/lock value, window address, write data, expected readback}
  localparam logic [31:0] VEC [8] = '{
    32'h40_08_81_81, 32'h40_09_18_18, 32'h80_0A_F0_F0, 32'h80_08_0F_0F,
    32'h00_09_FF_00, 32'hC0_08_FF_00, 32'h40_09_00_00, 32'h80_0A_00_00
  };

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1;
    @(negedge clk);
    reg_wen = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    chk("R1 pin_out", pin_out, 0);
    rd(4'd7, v); chk("R1 page/lock", v, 0);
    rd(4'd6, v); chk("R1 pending", v, 0);
    rd(4'd8, v); chk("R1 window", v, 0);
    chk("R1 irq", irq, 0);

    // R5 R9 table of window accesses
    for (int i = 0; i < 8; i++) begin
      wr(4'd7, VEC[i][31:24]);
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], v);
      chk($sformatf("R5/R9 vector %0d", i), v, VEC[i][7:0]);
    end
    do_reset();

    // R2 data registers
    wr(4'd0, 8'hA5); chk("R2 port0 out", pin_out[7:0], 8'hA5);
    wr(4'd5, 8'h3C); chk("R2 port5 out", pin_out[47:40], 8'h3C);
    pin_in[15:8] = 8'h96; settle();
    rd(4'd1, v); chk("R2 port1 read", v, 8'h96);
    pin_in = '0; settle();

    // R3 lock
    wr(4'd7, 8'h02); wr(4'd1, 8'hFF);
    chk("R3 locked port1", pin_out[15:8], 8'h00);
    rd(4'd7, v); chk("R3 page/lock readback", v, 8'h02);
    wr(4'd0, 8'h11); chk("R3 unlocked port0", pin_out[7:0], 8'h11);

    // R4 polarity capture
    wr(4'd7, 8'h40); wr(4'd8, 8'h01);
    wr(4'd7, 8'h80); wr(4'd8, 8'h03);
    wr(4'd7, 8'hC0);
    @(negedge clk) pin_in[0] = 1; settle();
    rd(4'd8, v); chk("R4 rising captured", v, 8'h01);
    rd(4'd6, v); chk("R7 pending port0", v, 8'h01);
    chk("R8 irq high", irq, 1);
    @(negedge clk) pin_in[1] = 1; settle();
    rd(4'd8, v); chk("R4 rising ignored on falling line", v, 8'h01);
    @(negedge clk) pin_in[1] = 0; settle();
    rd(4'd8, v); chk("R4 falling captured", v, 8'h03);
    @(negedge clk) pin_in[2] = 1; settle();
    @(negedge clk) pin_in[2] = 0; settle();
    rd(4'd8, v); chk("R4 disabled line", v, 8'h03);

    // R6 clear by re-enable
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd8, 8'h03);
    wr(4'd7, 8'hC0);
    rd(4'd8, v); chk("R6 cleared, no spurious", v, 8'h00);
    chk("R8 irq low", irq, 0);

    // R7 port2
    wr(4'd7, 8'h40); wr(4'd10, 8'h80);
    wr(4'd7, 8'h80); wr(4'd10, 8'h80);
    wr(4'd7, 8'hC0);
    @(negedge clk) pin_in[23] = 1; settle();
    rd(4'd10, v); chk("R6 id port2", v, 8'h80);
    rd(4'd6, v); chk("R7 pending port2", v, 8'h04);

    // R10 upper ports have no interrupt logic
    @(negedge clk) pin_in[47:24] = '1; settle();
    @(negedge clk) pin_in[47:24] = '0; settle();
    rd(4'd6, v); chk("R10 upper edges", v, 8'h04);

    // R9 page 0 and page 3 writes
    wr(4'd7, 8'h00); wr(4'd8, 8'hFF);
    rd(4'd8, v); chk("R9 page0 reads zero", v, 8'h00);
    wr(4'd7, 8'h40);
    rd(4'd8, v); chk("R9 polarity kept", v, 8'h01);
    wr(4'd7, 8'hC0); wr(4'd9, 8'hFF);
    wr(4'd7, 8'h80);
    rd(4'd9, v); chk("R9 page3 write ignored", v, 8'h00);
    rd(4'd8, v); chk("R9 enable kept", v, 8'h03);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule